// File: doc/BRIEF.md
# Inverted Page Table Address Translator

This block converts logical addresses inside a 32 MB logical RAM window into physical RAM addresses. The table holds one slot per physical page, 128 in all. It is therefore searched by content and never indexed by logical page. A write to the table carries all of its data in a single 23-bit word. The low seven bits of that word choose the slot. The remaining fields give the logical page number and a 2-bit protection level.

A separate control word sets two things. One is the page size: 4, 8, 16 or 32 KB. The other is an OS-mode flag that loosens write protection for supervisor accesses. The page size also changes which bits of a stored word form the logical page and which form the physical page.

A lookup is purely combinational. The requested logical page is compared against every valid slot at once. The lowest-numbered matching slot is selected, and its protection level is checked against the access kind (read or write) and the privilege (user or supervisor). The block then returns either a physical address or an abort. An abort covers both a missing mapping and a refused access.

Top module: `ipt_translator`

## Requirements
- R1: After a synchronous reset, every slot is invalid, the page size is 4 KB and OS mode is clear, so any requested lookup aborts until slots are written.
- R2: A cycle with `map_wr` high stores `map_word` into slot `map_word[6:0]`, replacing that slot's previous mapping.
- R3: A cycle with `cfg_wr` high loads the page size from `cfg_word[3:2]` (0 = 4 KB, 1 = 8 KB, 2 = 16 KB, 3 = 32 KB) and OS mode from `cfg_word[12]`; all other control bits have no effect.
- R4: With page size 4 KB × 2^s, the lookup's logical page is `lk_addr[24:12+s]`. A slot's logical page is `word[11:10]` placed directly above `word[22:12+s]`.
- R5: A slot's physical page number is `word[6:0]` for 4 KB; `{word[0], word[6:1]}` for 8 KB; `{word[1:0], word[6:2]}` for 16 KB; `{word[1], word[2], word[0], word[6:3]}` for 32 KB.
- R6: On a granted lookup, `lk_phys` is the physical page number followed by `lk_addr[11+s:0]`, zero-extended to 22 bits. Otherwise `lk_phys` is zero.
- R7: The protection level is `word[9:8]`. Level 0 permits everything. Level 1 refuses user writes. Levels 2 and 3 refuse every user access, and refuse supervisor writes unless OS mode is set.
- R8: A requested lookup that matches no valid slot, or that protection refuses, raises `lk_abort` and keeps `lk_ok` low.
- R9: When several valid slots hold the same logical page, the slot with the lowest index decides both the physical address and the protection.
- R10: The result appears in the same cycle as the request. With `lk_req` low, both `lk_ok` and `lk_abort` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_wr | input | 1 | Table slot write strobe |
| map_word | input | 23 | Address-encoded slot contents |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_word | input | 13 | Address-encoded control word |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 25 | Logical address |
| lk_write | input | 1 | Access is a write |
| lk_user | input | 1 | Access is from user mode |
| lk_ok | output | 1 | Translation granted |
| lk_abort | output | 1 | Miss or protection refusal |
| lk_phys | output | 22 | Physical address |

## Verification
The main function is tried with pseudo-random slot contents and random access kinds under each of the four page sizes. Under each size, the bit-field placement for both page numbers is distinct, so a wrong slice or wrong bit order produces a wrong address. A fixed table walks protection levels against user/supervisor, read/write and OS mode. This shows which of the three inputs each level actually consults. Directed cases follow with duplicate logical pages in two slots, an overwritten slot, and control words that carry noise in their unused bits. These separate priority and replacement from plain matching, and show that only the two decoded control fields matter.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

    localparam int SLOT_COUNT  = 128;
    localparam int MAP_WORD_W  = 23;
    localparam int CFG_WORD_W  = 13;
    localparam int LOG_ADDR_W  = 25;
    localparam int PHYS_ADDR_W = 22;
    localparam int LPN_W       = 13;
    localparam int PPN_W       = 7;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_8K  = 2'd1,
        PG_16K = 2'd2,
        PG_32K = 2'd3
    } pgsz_e;

    typedef struct packed {
        logic  os_mode;
        pgsz_e size;
    } xl_cfg_t;

    // Logical page of the request: address bits above the page offset.
    function automatic logic [LPN_W-1:0] addr_lpn(input logic [12:0] hi, input pgsz_e ps);
        case (ps)
            PG_4K:   return hi;
            PG_8K:   return {1'b0, hi[12:1]};
            PG_16K:  return {2'b0, hi[12:2]};
            default: return {3'b0, hi[12:3]};
        endcase
    endfunction

    // Logical page held in a slot; e is word[22:10].
    function automatic logic [LPN_W-1:0] entry_lpn(input logic [12:0] e, input pgsz_e ps);
        case (ps)
            PG_4K:   return {e[1:0], e[12:2]};
            PG_8K:   return {1'b0, e[1:0], e[12:3]};
            PG_16K:  return {2'b0, e[1:0], e[12:4]};
            default: return {3'b0, e[1:0], e[12:5]};
        endcase
    endfunction

    // Physical page held in a slot; p is word[6:0].
    function automatic logic [PPN_W-1:0] entry_ppn(input logic [6:0] p, input pgsz_e ps);
        case (ps)
            PG_4K:   return p;
            PG_8K:   return {p[0], p[6:1]};
            PG_16K:  return {p[1:0], p[6:2]};
            default: return {p[1], p[2], p[0], p[6:3]};
        endcase
    endfunction

    function automatic logic [PHYS_ADDR_W-1:0] phys_compose(input logic [PPN_W-1:0] ppn,
                                                            input logic [21:0] off,
                                                            input pgsz_e ps);
        case (ps)
            PG_4K:   return {3'b0, ppn, off[11:0]};
            PG_8K:   return {2'b0, ppn, off[12:0]};
            PG_16K:  return {1'b0, ppn, off[13:0]};
            default: return {ppn, off[14:0]};
        endcase
    endfunction

endpackage

// File: rtl/ipt_entry_store.sv
module ipt_entry_store
    import ipt_pkg::*;
#(
    parameter int ENTRIES = SLOT_COUNT,
    parameter int WORD_W  = MAP_WORD_W,
    parameter int LPN_BITS = LPN_W
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [WORD_W-1:0]               wr_word,
    input  pgsz_e                           page_size,
    input  logic [LPN_BITS-1:0]             req_lpn,
    output logic [ENTRIES-1:0]              match_vec,
    output logic [ENTRIES-1:0][WORD_W-1:0]  slot_words
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] slot_vld;
    logic [IDX_W-1:0]   wr_idx;

    assign wr_idx = wr_word[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_vld <= '0;
        end else if (wr_en) begin
            slot_vld[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slot_words[wr_idx] <= wr_word;
        end
    end

    // One comparator per slot, all evaluated in parallel.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = slot_vld[g] &&
                              (entry_lpn(slot_words[g][22:10], page_size) == req_lpn);
    end

    // R1: reset leaves no slot able to match
    a_r1_slots_cleared: assert property (@(posedge clk) rst |=> (slot_vld == '0));

    // R2: a write validates and loads exactly the addressed slot
    a_r2_slot_loaded: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (slot_vld[$past(wr_idx)] && slot_words[$past(wr_idx)] == $past(wr_word)));

endmodule

// File: rtl/ipt_prio_select.sv
module ipt_prio_select
    import ipt_pkg::*;
#(
    parameter int ENTRIES = SLOT_COUNT,
    parameter int WORD_W  = MAP_WORD_W
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [ENTRIES-1:0]              match_vec,
    input  logic [ENTRIES-1:0][WORD_W-1:0]  slot_words,
    output logic [ENTRIES-1:0]              grant,
    output logic                            any_hit,
    output logic [WORD_W-1:0]               sel_word
);
    // Isolate the lowest set bit: lowest slot index wins.
    assign grant   = match_vec & (~match_vec + {{(ENTRIES-1){1'b0}}, 1'b1});
    assign any_hit = |match_vec;

    always_comb begin
        sel_word = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            sel_word |= {WORD_W{grant[i]}} & slot_words[i];
        end
    end

    // R9: at most one slot is chosen, and only among matching ones
    a_r9_grant_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));
    a_r9_grant_subset: assert property (@(posedge clk) disable iff (rst)
        ((grant & ~match_vec) == '0) && (any_hit == (grant != '0)));

endmodule

// File: rtl/ipt_access_guard.sv
module ipt_access_guard (
    input  logic [1:0] level,
    input  logic       user,
    input  logic       write,
    input  logic       os_mode,
    output logic       deny
);
    always_comb begin
        unique case (level)
            2'd0:    deny = 1'b0;
            2'd1:    deny = user & write;
            default: deny = user | (write & ~os_mode);
        endcase
    end
endmodule

// File: rtl/ipt_translator.sv
module ipt_translator
    import ipt_pkg::*;
#(
    parameter int ENTRIES  = SLOT_COUNT,
    parameter int WORD_W   = MAP_WORD_W,
    parameter int CFG_W    = CFG_WORD_W,
    parameter int LADDR_W  = LOG_ADDR_W,
    parameter int PADDR_W  = PHYS_ADDR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               map_wr,
    input  logic [WORD_W-1:0]  map_word,
    input  logic               cfg_wr,
    input  logic [CFG_W-1:0]   cfg_word,
    input  logic               lk_req,
    input  logic [LADDR_W-1:0] lk_addr,
    input  logic               lk_write,
    input  logic               lk_user,
    output logic               lk_ok,
    output logic               lk_abort,
    output logic [PADDR_W-1:0] lk_phys
);
    xl_cfg_t                      cfg_q;
    logic [LPN_W-1:0]             req_lpn;
    logic [ENTRIES-1:0]           match_vec;
    logic [ENTRIES-1:0]           grant;
    logic [ENTRIES-1:0][WORD_W-1:0] slot_words;
    logic                         any_hit;
    logic [WORD_W-1:0]            sel_word;
    logic                         deny;
    logic                         granted;
    logic                         cfg_unused;
    logic                         sel_unused;

    assign cfg_unused = ^{cfg_word[11:4], cfg_word[1:0]};
    assign sel_unused = ^{sel_word[22:10], sel_word[7]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{os_mode: 1'b0, size: PG_4K};
        end else if (cfg_wr) begin
            cfg_q <= '{os_mode: cfg_word[12], size: pgsz_e'(cfg_word[3:2])};
        end
    end

    assign req_lpn = addr_lpn(lk_addr[24:12], cfg_q.size);

    ipt_entry_store #(.ENTRIES(ENTRIES), .WORD_W(WORD_W), .LPN_BITS(LPN_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (map_wr),
        .wr_word    (map_word),
        .page_size  (cfg_q.size),
        .req_lpn    (req_lpn),
        .match_vec  (match_vec),
        .slot_words (slot_words)
    );

    ipt_prio_select #(.ENTRIES(ENTRIES), .WORD_W(WORD_W)) u_prio (
        .clk        (clk),
        .rst        (rst),
        .match_vec  (match_vec),
        .slot_words (slot_words),
        .grant      (grant),
        .any_hit    (any_hit),
        .sel_word   (sel_word)
    );

    ipt_access_guard u_guard (
        .level   (sel_word[9:8]),
        .user    (lk_user),
        .write   (lk_write),
        .os_mode (cfg_q.os_mode),
        .deny    (deny)
    );

    assign granted  = any_hit & ~deny;
    assign lk_ok    = lk_req & granted;
    assign lk_abort = lk_req & ~granted;
    assign lk_phys  = lk_ok ? phys_compose(entry_ppn(sel_word[6:0], cfg_q.size),
                                           lk_addr[21:0], cfg_q.size)
                            : '0;

    // R1: control state returns to 4 KB pages with OS mode clear
    a_r1_cfg_reset: assert property (@(posedge clk)
        rst |=> (cfg_q.size == PG_4K && !cfg_q.os_mode));

    // R3: only the two decoded fields of the control word are taken
    a_r3_cfg_load: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (cfg_q.size == $past(cfg_word[3:2]) && cfg_q.os_mode == $past(cfg_word[12])));

    // R8: a lookup with no matching slot aborts
    a_r8_miss_abort: assert property (@(posedge clk) disable iff (rst)
        (lk_req && !any_hit) |-> (lk_abort && !lk_ok));

    // R7: an unprotected matching slot is always granted
    a_r7_level0_open: assert property (@(posedge clk) disable iff (rst)
        (lk_req && any_hit && sel_word[9:8] == 2'd0) |-> lk_ok);

    // R10: no request, no response; never both outcomes
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !lk_req |-> (!lk_ok && !lk_abort));
    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst) !(lk_ok && lk_abort));

    // R6: refused or missing lookups never expose an address
    a_r6_phys_zero: assert property (@(posedge clk) disable iff (rst)
        !lk_ok |-> (lk_phys == '0));

endmodule

// File: tb/ipt_translator_test.sv
module ipt_translator_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        map_wr;
    logic [22:0] map_word;
    logic        cfg_wr;
    logic [12:0] cfg_word;
    logic        lk_req;
    logic [24:0] lk_addr;
    logic        lk_write;
    logic        lk_user;
    logic        lk_ok;
    logic        lk_abort;
    logic [21:0] lk_phys;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference state kept by the bench.
    logic [22:0] m_words [128];
    bit          m_vld   [128];
    int          m_ps;
    bit          m_os;
    logic [31:0] lfsr = 32'hC0FFEE11;

    // Protection table: [5:4] level, [3] user, [2] write, [1] os, [0] expected abort
    localparam logic [5:0] PTAB [12] = '{
        6'b00_0_0_0_0, 6'b00_1_1_0_0, 6'b01_0_1_0_0, 6'b01_1_0_0_0,
        6'b01_1_1_0_1, 6'b10_0_0_0_0, 6'b10_0_1_0_1, 6'b10_0_1_1_0,
        6'b10_1_0_1_1, 6'b11_0_1_0_1, 6'b11_0_1_1_0, 6'b11_1_1_1_1
    };

    ipt_translator uut (
        .clk(clk), .rst(rst), .map_wr(map_wr), .map_word(map_word),
        .cfg_wr(cfg_wr), .cfg_word(cfg_word), .lk_req(lk_req), .lk_addr(lk_addr),
        .lk_write(lk_write), .lk_user(lk_user), .lk_ok(lk_ok), .lk_abort(lk_abort),
        .lk_phys(lk_phys)
    );

    always #2 clk = ~clk;

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        #(4 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        summary();
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr * 32'h9E3779B1;
    endfunction

    function automatic logic [12:0] ref_lpn(input logic [22:0] w, input int s);
        logic [12:0] top = {11'b0, w[11:10]};
        logic [12:0] low = {2'b0, w[22:12]};
        return (top << (11 - s)) | (low >> s);
    endfunction

    function automatic logic [6:0] ref_ppn(input logic [22:0] w, input int s);
        case (s)
            0:       return w[6:0];
            1:       return {w[0], w[6:1]};
            2:       return {w[1:0], w[6:2]};
            default: return {w[1], w[2], w[0], w[6:3]};
        endcase
    endfunction

    task automatic ref_xlate(input logic [24:0] a, input bit w, input bit u,
                             output bit ok, output logic [21:0] pa);
        logic [12:0] alpn;
        logic [1:0]  lvl;
        bit          allow;
        alpn = 13'(a[24:12] >> m_ps);
        ok = 1'b0;
        pa = '0;
        for (int i = 0; i < 128; i++) begin
            if (m_vld[i] && ref_lpn(m_words[i], m_ps) == alpn) begin
                lvl   = m_words[i][9:8];
                allow = (lvl == 2'd0) || (lvl == 2'd1 && !(u && w)) ||
                        (lvl[1] && !u && (!w || m_os));
                if (allow)
                    pa = ({15'b0, ref_ppn(m_words[i], m_ps)} << (12 + m_ps)) |
                         (a[21:0] & ((22'd1 << (12 + m_ps)) - 22'd1));
                ok = allow;
                return;
            end
        end
    endtask

    task automatic put_entry(input logic [22:0] w);
        @(negedge clk);
        map_wr   = 1'b1;
        map_word = w;
        @(negedge clk);
        map_wr = 1'b0;
        m_words[w[6:0]] = w;
        m_vld[w[6:0]]   = 1'b1;
    endtask

    task automatic put_cfg(input logic [12:0] c);
        @(negedge clk);
        cfg_wr   = 1'b1;
        cfg_word = c;
        @(negedge clk);
        cfg_wr = 1'b0;
        m_ps = int'(c[3:2]);
        m_os = c[12];
    endtask

    // Drive a lookup and compare all three outputs with the reference model.
    task automatic probe(input string req, input logic [24:0] a, input bit w, input bit u);
        bit          eok;
        logic [21:0] epa;
        @(negedge clk);
        lk_req = 1'b1; lk_addr = a; lk_write = w; lk_user = u;
        #1;
        ref_xlate(a, w, u, eok, epa);
        check(req, {31'b0, lk_ok}, {31'b0, eok});
        check(req, {31'b0, lk_abort}, {31'b0, !eok});
        check(req, {10'b0, lk_phys}, {10'b0, epa});
    endtask

    initial begin
        rst = 1'b1; map_wr = 0; map_word = '0; cfg_wr = 0; cfg_word = '0;
        lk_req = 0; lk_addr = '0; lk_write = 0; lk_user = 0;
        m_ps = 0; m_os = 0;
        for (int i = 0; i < 128; i++) begin
            m_vld[i] = 0; m_words[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10: idle request gives neither outcome
        #1;
        check("R10 idle ok", {31'b0, lk_ok}, 32'd0);
        check("R10 idle abort", {31'b0, lk_abort}, 32'd0);
        // R1: empty table after reset aborts
        @(negedge clk);
        lk_req = 1'b1; lk_addr = 25'h0; #1;
        check("R1 reset abort", {31'b0, lk_abort}, 32'd1);
        check("R1 reset ok", {31'b0, lk_ok}, 32'd0);

        // R7: protection table walk at 4 KB, slot 5, logical 0x1123abc
        for (int k = 0; k < 12; k++) begin
            logic [5:0] v;
            v = PTAB[k];
            put_cfg({v[1], 8'h00, 2'b00, 2'b00});
            put_entry({11'h123, 2'b10, v[5:4], 1'b0, 7'd5});
            @(negedge clk);
            lk_req = 1'b1; lk_addr = 25'h1123ABC; lk_user = v[3]; lk_write = v[2];
            #1;
            check("R7 prot abort", {31'b0, lk_abort}, {31'b0, v[0]});
            check("R6 prot phys", {10'b0, lk_phys}, v[0] ? 32'h0 : 32'h5ABC);
        end

        // R3: noise in unused control bits; OS mode stays clear, size stays 4 KB
        put_cfg(13'h0FF3);
        @(negedge clk);
        lk_req = 1'b1; lk_addr = 25'h1123ABC; lk_user = 0; lk_write = 1; #1;
        check("R3 os not set by noise", {31'b0, lk_abort}, 32'd1);
        lk_write = 0; #1;
        check("R3 size still 4K", {10'b0, lk_phys}, 32'h5ABC);

        // R9: slots 3 and 9 share logical page 0x0AB; slot 3 wins
        put_cfg(13'h0000);
        put_entry({11'h0AB, 2'b00, 2'b00, 1'b0, 7'd9});
        put_entry({11'h0AB, 2'b00, 2'b11, 1'b0, 7'd3});
        @(negedge clk);
        lk_req = 1'b1; lk_addr = 25'h00AB010; lk_user = 0; lk_write = 0; #1;
        check("R9 lowest slot phys", {10'b0, lk_phys}, 32'h3010);
        lk_user = 1; #1;
        check("R9 lowest slot protection", {31'b0, lk_abort}, 32'd1);
        // R2: overwrite slot 3 with another page; slot 9 now serves 0x0AB
        put_entry({11'h0CD, 2'b00, 2'b00, 1'b0, 7'd3});
        @(negedge clk);
        lk_addr = 25'h00AB010; lk_user = 0; #1;
        check("R2 overwrite phys", {10'b0, lk_phys}, 32'h9010);
        lk_addr = 25'h00CD020; #1;
        check("R2 new mapping phys", {10'b0, lk_phys}, 32'h3020);
        // R8: unmapped page aborts
        lk_addr = 25'h1FFF000; #1;
        check("R8 miss abort", {31'b0, lk_abort}, 32'd1);

        // R5: 32 KB scrambled page number, slot 5 -> ppn 0x30
        put_cfg({1'b0, 8'h00, 2'b11, 2'b00});
        put_entry(23'h2D0405);
        @(negedge clk);
        lk_addr = 25'h0AD1234; lk_user = 1; lk_write = 1; #1;
        check("R5 32K ppn order", {10'b0, lk_phys}, 32'h181234);

        // R4 R5 R6 R7 R9: random slots under each page size against the model
        for (int s = 0; s < 4; s++) begin
            logic [22:0] wl [20];
            put_cfg({s[0], 8'(rnd()), s[1:0], 2'(rnd())});
            for (int j = 0; j < 20; j++) begin
                wl[j] = 23'(rnd());
                put_entry(wl[j]);
            end
            for (int j = 0; j < 20; j++) begin
                logic [31:0] r;
                logic [24:0] a;
                r = rnd();
                a = (25'(ref_lpn(wl[j], s)) << (12 + s)) |
                    (25'(r) & ((25'd1 << (12 + s)) - 25'd1));
                probe("R4 R5 R6 random mapped", a, r[31], r[30]);
            end
            for (int j = 0; j < 6; j++) begin
                logic [31:0] r;
                r = rnd();
                probe("R8 random address", 25'(r), r[31], r[30]);
            end
        end

        @(negedge clk);
        lk_req = 1'b0;
        #1;
        check("R10 idle at end", {30'b0, lk_ok, lk_abort}, 32'd0);
        summary();
        $finish;
    end

endmodule